// File: doc/BRIEF.md
# Programmer-Side Memory Signature Reader

This controller sits inside a memory programmer. It fetches the two identification bytes from an attached one-time-programmable memory. A single start pulse begins the read. The controller first asks the analog supply to place the elevated identification voltage on the signature-select address line. It waits until the supply reports ready. It then reads two bytes, one with address bit 0 low and one with address bit 0 high, and keeps every other address bit low throughout.

Before each sample the controller waits for a programmable settle time with chip enable and output enable active. It captures the manufacturer and device bytes and checks odd parity on each, where bit 7 is the parity bit. When the read is complete it drops the voltage request, returns the address to zero and gives a one-cycle done pulse. The captured bytes and their error flags stay on the outputs until the next read replaces them.

Top module: `sigid_reader`

## Requirements
- R1: A start pulse in the idle state raises `hv_req_o` on the next cycle. Chip enable stays high (inactive) until `hv_ready_i` has been seen high.
- R2: Bits ADDR_W-1..1 of `mem_addr_o` are always 0. Bit 0 is 0 during the first access window and 1 during the second.
- R3: `mfr_code_o` holds the data bus value sampled in the window with address bit 0 at 0.
- R4: `dev_code_o` holds the data bus value sampled in the window with address bit 0 at 1.
- R5: `mfr_perr_o` and `dev_perr_o` are 1 exactly when their byte has an even number of 1 bits. Bit 7 is the parity bit, so a byte with odd parity gives 0.
- R6: Each access window keeps chip enable low for exactly SETTLE_CYC cycles, and the bus is sampled on the last of them. With `hv_ready_i` high in the cycle after start, `done_o` is high after the (2*SETTLE_CYC+3)-th rising edge, where the edge that samples start is the first.
- R7: `mem_ce_n_o` and `mem_oe_n_o` are always equal. Both are low only inside the two access windows, and both are 1 in reset, in idle, while waiting for ready, in the gap between the windows and in the done cycle.
- R8: A start pulse during a read has no effect. The read finishes with its normal timing and no second read follows.
- R9: `done_o` is high for exactly one cycle. In that cycle and afterwards `hv_req_o` is 0 and `mem_addr_o` is 0. The codes and flags keep their values until the next read.
- R10: During reset all outputs are 0, except the two enables, which are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a signature read |
| hv_ready_i | input | 1 | Identification voltage is present on the select line |
| mem_data_i | input | DATA_W | Memory data bus |
| hv_req_o | output | 1 | Request for the identification voltage |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mfr_code_o | output | DATA_W | Manufacturer byte |
| dev_code_o | output | DATA_W | Device byte |
| mfr_perr_o | output | 1 | Manufacturer byte has even parity |
| dev_perr_o | output | 1 | Device byte has even parity |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that the enables move together and go low only while the voltage request is up, that each capture happens with the enables active and with the correct level on address bit 0, that the settle counter stays in range, and that done is a single-cycle pulse followed by a released request. Only the bench scenarios can show that the captured bytes and parity flags match what the memory model presented, that each window lasts exactly the settle time, that a late ready stretches the read by the expected number of cycles, and that a start during a read causes no second read.

// File: rtl/sigid_pkg.sv
package sigid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HV_WAIT = 3'd1,
    ST_ACC_LO  = 3'd2,
    ST_GAP     = 3'd3,
    ST_ACC_HI  = 3'd4,
    ST_DONE    = 3'd5
  } sig_state_e;

  localparam int unsigned NUM_BYTES = 2;

endpackage

// File: rtl/sigid_settle.sv
module sigid_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    if (run_i && !expired_o) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0); // R6

endmodule

// File: rtl/sigid_parity.sv
module sigid_parity #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              even_o
);

  always_comb begin
    even_o = ~(^byte_i);
  end

endmodule

// File: rtl/sigid_ctrl.sv
module sigid_ctrl
  import sigid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hv_ready_i,
  input  logic expired_i,
  output logic run_o,
  output logic hv_req_o,
  output logic addr_bit_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic done_o
);

  sig_state_e state_q;
  sig_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)    state_d = ST_HV_WAIT;
      ST_HV_WAIT: if (hv_ready_i) state_d = ST_ACC_LO;
      ST_ACC_LO:  if (expired_i)  state_d = ST_GAP;
      ST_GAP:                     state_d = ST_ACC_HI;
      ST_ACC_HI:  if (expired_i)  state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    run_o      = (state_q == ST_ACC_LO) || (state_q == ST_ACC_HI);
    hv_req_o   = (state_q == ST_HV_WAIT) || (state_q == ST_ACC_LO) ||
                 (state_q == ST_GAP)     || (state_q == ST_ACC_HI);
    addr_bit_o = (state_q == ST_GAP) || (state_q == ST_ACC_HI);
    ce_n_o     = !run_o;
    oe_n_o     = !run_o;
    cap_lo_o   = (state_q == ST_ACC_LO) && expired_i;
    cap_hi_o   = (state_q == ST_ACC_HI) && expired_i;
    done_o     = (state_q == ST_DONE);
  end

  AST_ENABLE_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n_o |-> hv_req_o); // R1

  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_o == oe_n_o); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !hv_req_o && !addr_bit_o); // R9

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_HV_WAIT) |=> state_q != ST_HV_WAIT); // R8

  AST_FIRST_WINDOW_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n_o) && !addr_bit_o |-> $past(hv_ready_i)); // R1

endmodule

// File: rtl/sigid_reader.sv
module sigid_reader
  import sigid_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hv_ready_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              hv_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mfr_code_o,
  output logic [DATA_W-1:0] dev_code_o,
  output logic              mfr_perr_o,
  output logic              dev_perr_o,
  output logic              done_o
);

  localparam int unsigned UPPER_W = ADDR_W - 1;

  logic run_w;
  logic expired_w;
  logic addr_bit_w;
  logic cap_lo_w;
  logic cap_hi_w;
  logic even_w;

  logic [NUM_BYTES-1:0] cap_w;
  logic [DATA_W-1:0]    code_q [NUM_BYTES];
  logic [NUM_BYTES-1:0] perr_q;

  sigid_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .hv_ready_i (hv_ready_i),
    .expired_i  (expired_w),
    .run_o      (run_w),
    .hv_req_o   (hv_req_o),
    .addr_bit_o (addr_bit_w),
    .ce_n_o     (mem_ce_n_o),
    .oe_n_o     (mem_oe_n_o),
    .cap_lo_o   (cap_lo_w),
    .cap_hi_o   (cap_hi_w),
    .done_o     (done_o)
  );

  sigid_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .expired_o (expired_w)
  );

  sigid_parity #(.DATA_W(DATA_W)) u_parity (
    .byte_i (mem_data_i),
    .even_o (even_w)
  );

  assign cap_w      = {cap_hi_w, cap_lo_w};
  assign mem_addr_o = {{UPPER_W{1'b0}}, addr_bit_w};

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic              en;
    logic [DATA_W-1:0] code_d;
    logic              perr_d;

    always_comb begin
      en     = cap_w[g];
      code_d = mem_data_i;
      perr_d = even_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[g] <= '0;
        perr_q[g] <= 1'b0;
      end else if (en) begin
        code_q[g] <= code_d;
        perr_q[g] <= perr_d;
      end
    end
  end

  assign mfr_code_o = code_q[0];
  assign dev_code_o = code_q[1];
  assign mfr_perr_o = perr_q[0];
  assign dev_perr_o = perr_q[1];

  AST_LO_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo_w |-> !mem_ce_n_o && mem_addr_o == '0); // R3

  AST_HI_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi_w |-> !mem_ce_n_o && mem_addr_o[0]); // R4

  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_lo_w && !cap_hi_w |=> $stable(mfr_code_o) && $stable(dev_code_o)); // R9

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cap_w) <= 1); // R2

endmodule

// File: tb/tb_sigid_reader.sv
module tb_sigid_reader;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int SETTLE = 4;
  localparam int NVEC   = 6;

  // {mfr, dev, mfr_perr, dev_perr, ready_delay}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hC2, 8'h20, 1'b0, 1'b0, 6'd1},
    {8'h42, 8'h8F, 1'b1, 1'b0, 6'd1},
    {8'h01, 8'h00, 1'b0, 1'b1, 6'd5},
    {8'hFF, 8'h7F, 1'b1, 1'b0, 6'd2},
    {8'h80, 8'hA5, 1'b0, 1'b1, 6'd1},
    {8'h3C, 8'hD3, 1'b1, 1'b0, 6'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              ready;
  logic [DATA_W-1:0] mem_data;
  logic              hv_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              ce_n, oe_n;
  logic [DATA_W-1:0] mfr, dev;
  logic              mperr, dperr, done;
  logic [DATA_W-1:0] rom_mfr, rom_dev;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  assign mem_data = (!ce_n && !oe_n && hv_req) ? (mem_addr[0] ? rom_dev : rom_mfr) : 8'h00;

  sigid_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .hv_ready_i(ready),
    .mem_data_i(mem_data), .hv_req_o(hv_req), .mem_addr_o(mem_addr),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mfr_code_o(mfr), .dev_code_o(dev),
    .mfr_perr_o(mperr), .dev_perr_o(dperr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_read(input logic [7:0] m, input logic [7:0] d, input int dly,
                          input bit poke, output int edges, output int lo_cnt,
                          output int hi_cnt, output int addr_bad, output int strobe_bad,
                          output int wait_bad, output int hv_first);
    lo_cnt = 0; hi_cnt = 0; addr_bad = 0; strobe_bad = 0; wait_bad = 0;
    @(negedge clk);
    rom_mfr = m; rom_dev = d; ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    hv_first = hv_req;
    while (edges < 300) begin
      if (done) break;
      if (mem_addr[ADDR_W-1:1] != '0) addr_bad++;
      if (ce_n != oe_n) strobe_bad++;
      if (!ready && !ce_n) wait_bad++;
      if (!ce_n) begin
        if (mem_addr[0]) hi_cnt++;
        else             lo_cnt++;
      end
      start = (poke && (edges == 3 || edges == SETTLE + 4)) ? 1'b1 : 1'b0;
      if (edges == dly) ready = 1'b1;
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int edges, lo_cnt, hi_cnt, addr_bad, strobe_bad, wait_bad, hv_first;
    rst_n = 1'b0; start = 1'b0; ready = 1'b0; rom_mfr = '0; rom_dev = '0;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(hv_req == 1'b0, "R10", "hv_req in reset", hv_req, 0);
    chk(ce_n == 1'b1 && oe_n == 1'b1, "R10", "enables in reset", {ce_n, oe_n}, 2'b11);
    chk(mem_addr == '0, "R10", "addr in reset", mem_addr, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(mfr == '0 && dev == '0, "R10", "codes in reset", {mfr, dev}, 0);
    chk(mperr == 1'b0 && dperr == 1'b0, "R10", "flags in reset", {mperr, dperr}, 0);

    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(hv_req == 1'b0 && ce_n == 1'b1, "R7", "idle after reset", {hv_req, ce_n}, 2'b01);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] vm, vd;
      logic       em, ed;
      int         dly;
      bit         poke;
      vm = VEC[i][23:16]; vd = VEC[i][15:8];
      em = VEC[i][7];     ed = VEC[i][6];
      dly = int'(VEC[i][5:0]);
      poke = (i == 4);
      run_read(vm, vd, dly, poke, edges, lo_cnt, hi_cnt, addr_bad, strobe_bad, wait_bad, hv_first);

      chk(hv_first == 1, "R1", $sformatf("vec%0d hv_req after start", i), hv_first, 1);
      chk(wait_bad == 0, "R1", $sformatf("vec%0d enable before ready", i), wait_bad, 0);
      chk(edges == 2*SETTLE + 2 + dly, "R6", $sformatf("vec%0d start-to-done edges", i),
          edges, 2*SETTLE + 2 + dly);
      chk(lo_cnt == SETTLE, "R6", $sformatf("vec%0d low window length", i), lo_cnt, SETTLE);
      chk(hi_cnt == SETTLE, "R2", $sformatf("vec%0d high window length", i), hi_cnt, SETTLE);
      chk(addr_bad == 0, "R2", $sformatf("vec%0d upper address bits", i), addr_bad, 0);
      chk(strobe_bad == 0, "R7", $sformatf("vec%0d ce/oe mismatch", i), strobe_bad, 0);
      chk(hv_req == 1'b0 && mem_addr == '0 && ce_n == 1'b1, "R9",
          $sformatf("vec%0d release in done cycle", i), {hv_req, mem_addr[0], ce_n}, 3'b001);
      chk(mfr == vm, "R3", $sformatf("vec%0d manufacturer byte", i), mfr, vm);
      chk(dev == vd, "R4", $sformatf("vec%0d device byte", i), dev, vd);
      chk(mperr == em, "R5", $sformatf("vec%0d manufacturer parity flag", i), mperr, em);
      chk(dperr == ed, "R5", $sformatf("vec%0d device parity flag", i), dperr, ed);

      ready = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R9", $sformatf("vec%0d done width", i), done, 0);
      repeat (SETTLE + 3) @(negedge clk);
      chk(hv_req == 1'b0 && ce_n == 1'b1, "R8", $sformatf("vec%0d no further read", i),
          {hv_req, ce_n}, 2'b01);
      chk(mfr == vm && dev == vd, "R9", $sformatf("vec%0d codes held", i), {mfr, dev}, {vm, vd});
    end

    // R7: waiting for ready keeps enables high and address low
    @(negedge clk);
    start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(hv_req == 1'b1 && ce_n == 1'b1 && oe_n == 1'b1 && mem_addr == '0, "R7",
        "hold during ready wait", {hv_req, ce_n, oe_n, mem_addr[0]}, 4'b1110);
    ready = 1'b1;
    repeat (2*SETTLE + 4) @(negedge clk);
    ready = 1'b0;
    chk(hv_req == 1'b0 && done == 1'b0, "R9", "late-ready read completed", {hv_req, done}, 0);

    // R10: reset in the middle of a read returns everything to idle
    start = 1'b1; ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(hv_req == 1'b0 && ce_n == 1'b1 && mfr == '0, "R10", "mid-read reset",
        {hv_req, ce_n, mfr}, 10'h100);
    rst_n = 1'b1; ready = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule